// File: doc/BRIEF.md
# Filtered Reset Sequencer

This block conditions an external active-low reset pin that may be asynchronous and noisy. It turns the pin into a clean internal reset that lasts a known minimum time. The pin is first brought into the clock domain through a two-stage synchronizer. A run counter then looks for a sustained low level. A low level that lasts only a few clocks is treated as a glitch and ignored. Once the low level has lasted long enough, the internal reset is latched. It is then held for a fixed minimum number of clocks, or for longer if the pin is still low.

While the internal reset is active, the block overrides the two bus strobes. The data strobe is held low. The address strobe toggles on every clock, so it runs at half the clock rate. When the internal reset drops, the block pulses a program-counter load for one cycle. During that pulse it presents the fixed start vector 0x000C.

A separate synchronous active-high power-on reset clears the block to its idle state.

Top module: `reset_sequencer`

## Requirements
- R1: A low level on `ext_rst_n` that lasts four or fewer clock periods produces no internal reset. `rst_int` stays 0.
- R2: A single high sample inside a run of low samples restarts the glitch count. Two low runs of four clocks each, split by one high clock, produce no reset.
- R3: The fifth consecutive low synchronized sample latches the internal reset. `ext_rst_n` is driven low just after a clock edge and held low. `rst_int` is then first seen high after the seventh rising edge that follows: two synchronizer stages plus five filter samples.
- R4: Once latched, `rst_int` stays high for at least 18 clocks. A pulse of 5 to 22 clocks gives exactly 18 clocks of reset. Low re-pulses on the pin during the hold neither extend nor restart it.
- R5: If the pin stays low longer, `rst_int` stays high until the synchronized pin is seen high. For a single low pulse of L clocks (L ≥ 5), the reset length is max(18, L − 4) clocks.
- R6: `ds_n` is 0 in every cycle that `rst_int` is 1, and 1 in every other cycle.
- R7: `as_n` is 0 in the first cycle of internal reset and inverts on every later reset cycle. It is 1 whenever `rst_int` is 0.
- R8: `pc_load` is 1 for exactly one cycle: the first cycle after `rst_int` falls. In that cycle `start_addr` equals 16'h000C.
- R9: While `rst` is sampled high at a clock edge, the block returns to idle at that edge. After that edge `rst_int`=0, `ds_n`=1, `as_n`=1 and `pc_load`=0, even in the middle of a held reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on clear |
| ext_rst_n | input | 1 | Asynchronous active-low external reset pin |
| rst_int | output | 1 | Filtered, stretched internal reset, active high |
| ds_n | output | 1 | Data strobe override, low during reset |
| as_n | output | 1 | Address strobe override, toggles during reset |
| pc_load | output | 1 | One-cycle program-counter load after reset ends |
| start_addr | output | 16 | Start vector presented with `pc_load` |

## Verification
A filter count that is wrong shows up at `rst_int` as a reset that either appears after a short glitch or is missing after a valid pulse. The first sign is a rising edge one or more cycles away from the seventh edge. A stretch count that is wrong changes the measured reset length, and the error is visible at the falling edge of `rst_int` within the same pulse. A strobe generator that is wrong breaks the alternation of `as_n`, or lets `ds_n` rise, on the very first cycle of reset.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [0:0] {
        SEQ_RUN  = 1'b0,
        SEQ_HOLD = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic ds_n;
        logic as_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ds_n: 1'b1, as_n: 1'b1};

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic pin_s
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], pin_n};
    end

    assign pin_s = chain[STAGES-1];
endmodule

// File: rtl/rsq_filter.sv
module rsq_filter #(
    parameter int unsigned FILTER_CLKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_s,
    output logic fire
);
    import rsq_pkg::*;
    localparam int unsigned FW = cnt_width(FILTER_CLKS);
    localparam logic [FW-1:0] FULL = FW'(FILTER_CLKS);

    logic [FW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || pin_s)      low_run <= '0;
        else if (low_run != FULL) low_run <= low_run + 1'b1;
    end

    // the sample after FILTER_CLKS consecutive lows is the latching one
    assign fire = !pin_s && (low_run == FULL);
endmodule

// File: rtl/rsq_stretch.sv
module rsq_stretch #(
    parameter int unsigned STRETCH_CLKS = 18
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic pin_s,
    output logic hold,
    output logic hold_next,
    output logic done
);
    import rsq_pkg::*;
    localparam int unsigned SW = cnt_width(STRETCH_CLKS);
    localparam logic [SW-1:0] LAST = SW'(STRETCH_CLKS - 1);

    seq_state_e    state, state_d;
    logic [SW-1:0] cnt;
    logic          release_now;

    assign release_now = (state == SEQ_HOLD) && (cnt == LAST) && pin_s;

    always_comb begin
        state_d = state;
        unique case (state)
            SEQ_RUN:  if (fire)        state_d = SEQ_HOLD;
            SEQ_HOLD: if (release_now) state_d = SEQ_RUN;
            default:                   state_d = SEQ_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_RUN;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            state <= state_d;
            done  <= release_now;
            if (state == SEQ_RUN)  cnt <= '0;
            else if (cnt != LAST)  cnt <= cnt + 1'b1;
        end
    end

    assign hold      = (state == SEQ_HOLD);
    assign hold_next = (state_d == SEQ_HOLD);
endmodule

// File: rtl/rsq_strobe.sv
module rsq_strobe (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             hold_next,
    output rsq_pkg::strobe_t strobe
);
    import rsq_pkg::*;

    always_ff @(posedge clk) begin
        if (rst || !hold_next) begin
            strobe <= STROBE_IDLE;
        end else begin
            strobe.ds_n <= 1'b0;
            strobe.as_n <= hold ? ~strobe.as_n : 1'b0;
        end
    end
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned FILTER_CLKS  = 4,
    parameter int unsigned STRETCH_CLKS = 18,
    parameter int unsigned ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] START_ADDR = ADDR_W'(16'h000C)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_rst_n,
    output logic              rst_int,
    output logic              ds_n,
    output logic              as_n,
    output logic              pc_load,
    output logic [ADDR_W-1:0] start_addr
);
    import rsq_pkg::*;

    logic    pin_s;
    logic    fire;
    logic    hold, hold_next;
    strobe_t strobe;

    rsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_n(ext_rst_n), .pin_s(pin_s)
    );

    rsq_filter #(.FILTER_CLKS(FILTER_CLKS)) u_filter (
        .clk(clk), .rst(rst), .pin_s(pin_s), .fire(fire)
    );

    rsq_stretch #(.STRETCH_CLKS(STRETCH_CLKS)) u_stretch (
        .clk(clk), .rst(rst), .fire(fire), .pin_s(pin_s),
        .hold(hold), .hold_next(hold_next), .done(pc_load)
    );

    rsq_strobe u_strobe (
        .clk(clk), .rst(rst), .hold(hold), .hold_next(hold_next),
        .strobe(strobe)
    );

    assign rst_int    = hold;
    assign ds_n       = strobe.ds_n;
    assign as_n       = strobe.as_n;
    assign start_addr = START_ADDR;
endmodule

// File: rtl/rsq_chk.sv
module rsq_chk #(
    parameter int unsigned STRETCH_CLKS = 18
) (
    input logic clk,
    input logic rst,
    input logic pin_s,
    input logic rst_int,
    input logic ds_n,
    input logic as_n,
    input logic pc_load
);
    localparam int unsigned LW = $clog2(STRETCH_CLKS + 1) + 1;
    localparam logic [LW-1:0] SAT = LW'(STRETCH_CLKS);

    logic [LW-1:0] len;

    always_ff @(posedge clk) begin
        if (rst || !rst_int) len <= '0;
        else if (len != SAT) len <= len + 1'b1;
    end

    // R4
    min_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_int) |-> (len == SAT));

    // R5
    release_on_high_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_int) |-> $past(pin_s));

    // R6
    ds_low_chk: assert property (@(posedge clk) disable iff (rst)
        rst_int |-> !ds_n);

    // R7
    as_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_int && $past(rst_int)) |-> (as_n != $past(as_n)));

    // R7
    as_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rst_int |-> as_n);

    // R8
    load_after_chk: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> (!rst_int && $past(rst_int)));
endmodule

bind reset_sequencer rsq_chk #(.STRETCH_CLKS(STRETCH_CLKS)) u_chk (
    .clk(clk), .rst(rst), .pin_s(pin_s), .rst_int(rst_int),
    .ds_n(ds_n), .as_n(as_n), .pc_load(pc_load)
);

// File: tb/tb_reset_sequencer.sv
module tb_reset_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin = 1'b1;
    logic        rst_int, ds_n, as_n, pc_load;
    logic [15:0] start_addr;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    reset_sequencer dut (
        .clk(clk), .rst(rst), .ext_rst_n(pin), .rst_int(rst_int),
        .ds_n(ds_n), .as_n(as_n), .pc_load(pc_load), .start_addr(start_addr)
    );

    function automatic int exp_len(int l);
        if (l < 5) return 0;
        return (l - 4 > 18) ? l - 4 : 18;
    endfunction

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // pin low for l1 clocks, high for h, low for l2, then high
    task automatic run_case(int l1, int h, int l2, int exp, string req_len);
        int   rc = 0, pcs = 0, bad_ds = 0, bad_as = 0, bad_pc = 0;
        logic prev_rst = 1'b0, prev_as = 1'b1;
        for (int i = 0; i < l1 + h + l2 + 60; i++) begin
            @(negedge clk);
            if (rst_int) begin
                rc++;
                if (ds_n !== 1'b0) bad_ds++;
                if (prev_rst && as_n === prev_as) bad_as++;
                if (!prev_rst && as_n !== 1'b0) bad_as++;
            end else begin
                if (ds_n !== 1'b1) bad_ds++;
                if (as_n !== 1'b1) bad_as++;
            end
            if (pc_load) begin
                pcs++;
                if (!(prev_rst && !rst_int) || start_addr !== 16'h000C) bad_pc++;
            end else if (prev_rst && !rst_int) bad_pc++;
            prev_rst = rst_int;
            prev_as  = as_n;
            if (i < l1)                pin = 1'b0;
            else if (i < l1 + h)       pin = 1'b1;
            else if (i < l1 + h + l2)  pin = 1'b0;
            else                       pin = 1'b1;
        end
        check(req_len, rc, exp);
        check("R6 ds_n low exactly during reset", bad_ds, 0);
        check("R7 as_n pattern", bad_as, 0);
        check("R8 pc_load count", pcs, (exp > 0) ? 1 : 0);
        check("R8 pc_load timing/start_addr", bad_pc, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int dummy;
        int first;
        dummy = $urandom(32'h5EED);
        repeat (4) @(negedge clk);
        // R9 reset state
        check("R9 rst_int in reset", rst_int, 0);
        check("R9 ds_n in reset", ds_n, 1);
        check("R9 as_n in reset", as_n, 1);
        check("R9 pc_load in reset", pc_load, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R3 latency: first high seen at the seventh negedge after drive
        pin = 1'b0;
        first = 0;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (rst_int && first == 0) first = k;
        end
        check("R3 latch latency", first, 7);
        pin = 1'b1;
        repeat (40) @(negedge clk);

        run_case(4, 0, 0, 0, "R1 four-clock glitch ignored");
        run_case(1, 0, 0, 0, "R1 one-clock glitch ignored");
        run_case(4, 1, 4, 0, "R2 high sample restarts count");
        run_case(5, 0, 0, 18, "R4 minimum pulse length");
        run_case(22, 0, 0, 18, "R4 longest pulse at minimum");
        run_case(10, 3, 5, 18, "R4 re-pulse during hold ignored");
        run_case(23, 0, 0, 19, "R5 pin extends reset");
        run_case(40, 0, 0, 36, "R5 long pin low");

        for (int r = 0; r < 20; r++) begin
            int l;
            l = 1 + int'($urandom % 36);
            run_case(l, 0, 0, exp_len(l),
                     (l < 5) ? "R1 random glitch" : (l <= 22 ? "R4 random pulse" : "R5 random pulse"));
        end

        // R9 clear in the middle of a held reset
        pin = 1'b0;
        repeat (12) @(negedge clk);
        check("R9 reset active before clear", rst_int, 1);
        rst = 1'b1;
        @(negedge clk);
        check("R9 rst_int cleared", rst_int, 0);
        check("R9 ds_n cleared", ds_n, 1);
        check("R9 as_n cleared", as_n, 1);
        check("R9 pc_load cleared", pc_load, 0);
        pin = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule